// File: doc/BRIEF.md
# Quota-Aware Victim Selector for a Shared Cache Set

This block chooses which way of one set of a shared, core-partitioned cache is replaced on a miss, and returns the updated ownership, recency and valid state of that set. The caller presents the set's per-way owner tags, recency ranks and valid bits, the identifier of the requesting core and that core's way quota for the set. It also presents a strobe that marks the access as a hit or a miss. One cycle later the block returns the chosen way, the reason for the choice, and the next owner, rank and valid vectors for writing back into the set's state.

On a miss, any invalid way is taken first. Otherwise the block counts the valid ways the requester already holds. A requester holding fewer ways than its quota grows by evicting the oldest line of another core. A requester at or over its quota replaces its own oldest line. If the preferred group has no lines, the other group is used. Hits only refresh recency. Tag lookup, data arrays and the computation of the quotas sit outside the block.

Top module: `vic_select`

## Requirements
- R1: On a miss where any way has its valid bit at 0, the victim is the lowest-numbered invalid way, whatever the owners, and `out_src` is 1.
- R2: On a miss with all ways valid, the requester's held-way count is the number of valid ways whose owner field equals `req_core`. When that count is below `quota` and another core holds at least one way, the victim is the way with the highest rank among lines not owned by the requester, and `out_src` is 2.
- R3: On a miss with all ways valid, when the count is at or above `quota` and the requester holds at least one way, the victim is the requester's own way with the highest rank, and `out_src` is 3.
- R4: If the preferred group of R2 or R3 has no lines, the victim is the highest-ranked way of the other group, and `out_src` names the group actually used.
- R5: On a miss, the owner field of the victim way in `owner_nxt` becomes `req_core`, and all other owner fields pass through. On a hit, all owner fields pass through unchanged and `out_src` is 0. Owner field i sits at bits [i*CW +: CW].
- R6: Ranks are exact, with 0 being the most recent, and rank i of way i sits at bits [i*AW +: AW]. On any access, the accessed way (hit way or victim) gets rank 0. Every way with a rank below the accessed way's old rank gains 1, and all other ranks are unchanged.
- R7: `valid_nxt` equals `line_valid` with the accessed way's bit set.
- R8: `out_valid` is high exactly in the cycle after a cycle with `req_valid` high, and the other outputs are valid in that cycle.
- R9: During and directly after reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access strobe |
| req_hit | input | 1 | 1 = hit at `req_hit_way`, 0 = miss |
| req_hit_way | input | AW | Way that hit |
| req_core | input | CW | Requesting core |
| quota | input | QW | Way quota of the requester in this set |
| line_valid | input | WAYS | Per-way valid bits |
| line_owner | input | WAYS*CW | Per-way owner fields |
| line_age | input | WAYS*AW | Per-way recency ranks |
| out_valid | output | 1 | Result strobe |
| out_way | output | AW | Accessed or victim way |
| out_src | output | 2 | 0 hit, 1 invalid way, 2 other core's line, 3 own line |
| owner_nxt | output | WAYS*CW | Next owner fields |
| age_nxt | output | WAYS*AW | Next ranks |
| valid_nxt | output | WAYS | Next valid bits |

## Verification
The bench builds the block with 8 ways and 4 cores, so CW is 2, AW is 3 and QW is 4. With 8 ways, every rank permutation and owner layout can be written out by hand, and a quota of 0, a quota exactly equal to the held count and a quota above the way count all fit in the 4-bit field. This brings the fallback paths of R4 in both directions, and the rank shifts of R6 for an accessed way in the middle of the order, within reach of short directed cases.

// File: rtl/vs_pkg.sv
package vs_pkg;

    typedef enum logic [1:0] {
        SRC_HIT     = 2'd0,
        SRC_INVALID = 2'd1,
        SRC_OTHER   = 2'd2,
        SRC_OWN     = 2'd3
    } src_t;

    localparam int DEF_WAYS  = 32;
    localparam int DEF_CORES = 8;

endpackage

// File: rtl/vs_owner_count.sv
module vs_owner_count #(
    parameter int WAYS = 32,
    parameter int CW   = 3,
    parameter int QW   = 6
) (
    input  logic [WAYS-1:0]    valid,
    input  logic [WAYS*CW-1:0] owner,
    input  logic [CW-1:0]      core,
    output logic [WAYS-1:0]    own_mask,
    output logic [QW-1:0]      count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < WAYS; i++) begin
            own_mask[i] = (owner[i*CW +: CW] == core);
            if (own_mask[i] && valid[i])
                count = count + QW'(1);
        end
    end
endmodule

// File: rtl/vs_lru_pick.sv
module vs_lru_pick #(
    parameter int WAYS = 32,
    parameter int AW   = 5
) (
    input  logic [WAYS-1:0]    mask,
    input  logic [WAYS*AW-1:0] ages,
    output logic               found,
    output logic [AW-1:0]      way
);
    logic [AW-1:0] best;
    always_comb begin
        found = 1'b0;
        way   = '0;
        best  = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (mask[i] && (!found || ages[i*AW +: AW] > best)) begin
                found = 1'b1;
                way   = AW'(i);
                best  = ages[i*AW +: AW];
            end
        end
    end
endmodule

// File: rtl/vs_rank_update.sv
module vs_rank_update #(
    parameter int WAYS = 32,
    parameter int AW   = 5
) (
    input  logic [WAYS*AW-1:0] ages,
    input  logic [AW-1:0]      way,
    output logic [WAYS*AW-1:0] ages_nxt
);
    logic [AW-1:0] old_rank;
    always_comb begin
        old_rank = ages[way*AW +: AW];
        for (int i = 0; i < WAYS; i++) begin
            if (AW'(i) == way)
                ages_nxt[i*AW +: AW] = '0;
            else if (ages[i*AW +: AW] < old_rank)
                ages_nxt[i*AW +: AW] = ages[i*AW +: AW] + AW'(1);
            else
                ages_nxt[i*AW +: AW] = ages[i*AW +: AW];
        end
    end
endmodule

// File: rtl/vic_select.sv
module vic_select
    import vs_pkg::*;
#(
    parameter int WAYS  = DEF_WAYS,
    parameter int CORES = DEF_CORES,
    localparam int CW   = (CORES > 1) ? $clog2(CORES) : 1,
    localparam int AW   = $clog2(WAYS),
    localparam int QW   = $clog2(WAYS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_hit,
    input  logic [AW-1:0]      req_hit_way,
    input  logic [CW-1:0]      req_core,
    input  logic [QW-1:0]      quota,
    input  logic [WAYS-1:0]    line_valid,
    input  logic [WAYS*CW-1:0] line_owner,
    input  logic [WAYS*AW-1:0] line_age,
    output logic               out_valid,
    output logic [AW-1:0]      out_way,
    output logic [1:0]         out_src,
    output logic [WAYS*CW-1:0] owner_nxt,
    output logic [WAYS*AW-1:0] age_nxt,
    output logic [WAYS-1:0]    valid_nxt
);
    logic [WAYS-1:0] own_mask;
    logic [QW-1:0]   held;
    logic            own_found, oth_found, inv_found;
    logic [AW-1:0]   own_way, oth_way, inv_way, sel_way;
    src_t            sel_src;
    logic [WAYS*AW-1:0] ranks_upd;

    vs_owner_count #(.WAYS(WAYS), .CW(CW), .QW(QW)) u_cnt (
        .valid(line_valid), .owner(line_owner), .core(req_core),
        .own_mask(own_mask), .count(held)
    );

    vs_lru_pick #(.WAYS(WAYS), .AW(AW)) u_pick_own (
        .mask(own_mask), .ages(line_age), .found(own_found), .way(own_way)
    );

    vs_lru_pick #(.WAYS(WAYS), .AW(AW)) u_pick_oth (
        .mask(~own_mask), .ages(line_age), .found(oth_found), .way(oth_way)
    );

    // lowest-numbered invalid way: scan from the top so the lowest wins
    always_comb begin
        inv_found = 1'b0;
        inv_way   = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!line_valid[i]) begin
                inv_found = 1'b1;
                inv_way   = AW'(i);
            end
        end
    end

    always_comb begin
        if (req_hit) begin
            sel_src = SRC_HIT;
            sel_way = req_hit_way;
        end else if (inv_found) begin
            sel_src = SRC_INVALID;
            sel_way = inv_way;
        end else if (held < quota) begin
            sel_src = oth_found ? SRC_OTHER : SRC_OWN;
            sel_way = oth_found ? oth_way : own_way;
        end else begin
            sel_src = own_found ? SRC_OWN : SRC_OTHER;
            sel_way = own_found ? own_way : oth_way;
        end
    end

    vs_rank_update #(.WAYS(WAYS), .AW(AW)) u_rank (
        .ages(line_age), .way(sel_way), .ages_nxt(ranks_upd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_way   <= '0;
            out_src   <= SRC_HIT;
            owner_nxt <= '0;
            age_nxt   <= '0;
            valid_nxt <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_way   <= sel_way;
                out_src   <= sel_src;
                age_nxt   <= ranks_upd;
                valid_nxt <= line_valid | (WAYS'(1) << sel_way);
                for (int i = 0; i < WAYS; i++) begin
                    if (!req_hit && AW'(i) == sel_way)
                        owner_nxt[i*CW +: CW] <= req_core;
                    else
                        owner_nxt[i*CW +: CW] <= line_owner[i*CW +: CW];
                end
            end
        end
    end
endmodule

// File: rtl/vic_select_chk.sv
module vic_select_chk #(
    parameter int WAYS = 32,
    parameter int CW   = 3,
    parameter int AW   = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_hit,
    input logic [CW-1:0]      req_core,
    input logic [WAYS-1:0]    line_valid,
    input logic [WAYS*CW-1:0] line_owner,
    input logic               out_valid,
    input logic [AW-1:0]      out_way,
    input logic [1:0]         out_src,
    input logic [WAYS*CW-1:0] owner_nxt,
    input logic [WAYS*AW-1:0] age_nxt,
    input logic [WAYS-1:0]    valid_nxt
);
    logic               p_req, p_hit;
    logic [CW-1:0]      p_core;
    logic [WAYS-1:0]    p_valid;
    logic [WAYS*CW-1:0] p_owner;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_req <= 1'b0; p_hit <= 1'b0; p_core <= '0;
            p_valid <= '0; p_owner <= '0;
        end else begin
            p_req <= req_valid; p_hit <= req_hit; p_core <= req_core;
            p_valid <= line_valid; p_owner <= line_owner;
        end
    end

    assert_strobe_latency_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid == p_req);

    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> !out_valid);

    assert_invalid_first_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !p_hit && p_valid != '1) |-> !p_valid[out_way]);

    assert_other_owner_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_src == 2'd2) |-> p_owner[out_way*CW +: CW] != p_core);

    assert_own_owner_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_src == 2'd3) |-> p_owner[out_way*CW +: CW] == p_core);

    assert_fill_owner_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !p_hit) |-> owner_nxt[out_way*CW +: CW] == p_core);

    assert_mru_zero_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> age_nxt[out_way*AW +: AW] == '0);

    assert_fill_valid_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> valid_nxt[out_way]);
endmodule

bind vic_select vic_select_chk #(.WAYS(WAYS), .CW(CW), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_hit(req_hit),
    .req_core(req_core), .line_valid(line_valid), .line_owner(line_owner),
    .out_valid(out_valid), .out_way(out_way), .out_src(out_src),
    .owner_nxt(owner_nxt), .age_nxt(age_nxt), .valid_nxt(valid_nxt)
);

// File: tb/vic_select_test.sv
module vic_select_test;
    localparam int WAYS = 8, CORES = 4, CW = 2, AW = 3, QW = 4;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_hit = 0;
    logic [AW-1:0] req_hit_way = '0;
    logic [CW-1:0] req_core = '0;
    logic [QW-1:0] quota = '0;
    logic [WAYS-1:0] line_valid = '0;
    logic [WAYS*CW-1:0] line_owner = '0;
    logic [WAYS*AW-1:0] line_age = '0;
    logic out_valid;
    logic [AW-1:0] out_way;
    logic [1:0] out_src;
    logic [WAYS*CW-1:0] owner_nxt;
    logic [WAYS*AW-1:0] age_nxt;
    logic [WAYS-1:0] valid_nxt;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vic_select #(.WAYS(WAYS), .CORES(CORES)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_hit(req_hit),
        .req_hit_way(req_hit_way), .req_core(req_core), .quota(quota),
        .line_valid(line_valid), .line_owner(line_owner), .line_age(line_age),
        .out_valid(out_valid), .out_way(out_way), .out_src(out_src),
        .owner_nxt(owner_nxt), .age_nxt(age_nxt), .valid_nxt(valid_nxt)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [WAYS*AW-1:0] ranks_up();   // way i has rank i
        logic [WAYS*AW-1:0] v;
        for (int i = 0; i < WAYS; i++) v[i*AW +: AW] = AW'(i);
        return v;
    endfunction

    function automatic logic [WAYS*AW-1:0] ranks_down(); // way i has rank 7-i
        logic [WAYS*AW-1:0] v;
        for (int i = 0; i < WAYS; i++) v[i*AW +: AW] = AW'(WAYS - 1 - i);
        return v;
    endfunction

    function automatic logic [WAYS*CW-1:0] owners_split(int lo, int hi);
        logic [WAYS*CW-1:0] v;
        for (int i = 0; i < WAYS; i++) v[i*CW +: CW] = CW'((i < 4) ? lo : hi);
        return v;
    endfunction

    // one access: drive on falling edge, result sampled one cycle later
    task automatic access(bit hit, int hway, int core, int q);
        @(negedge clk);
        req_valid = 1; req_hit = hit; req_hit_way = AW'(hway);
        req_core = CW'(core); quota = QW'(q);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic t_reset();
        check("R9 out_valid in reset", 64'(out_valid), 0);
        @(negedge clk); rst = 0;
        @(negedge clk);
        check("R9 out_valid after reset", 64'(out_valid), 0);
    endtask

    task automatic t_invalid_first();
        logic [WAYS*AW-1:0] e;
        line_valid = 8'b1111_0011; line_owner = owners_split(1, 2);
        line_age = ranks_up();
        access(0, 0, 3, 0);
        check("R8 out_valid", 64'(out_valid), 1);
        check("R1 victim", 64'(out_way), 2);
        check("R1 src", 64'(out_src), 1);
        check("R5 owner of victim", 64'(owner_nxt[2*CW +: CW]), 3);
        check("R5 other owners", 64'(owner_nxt & ~(16'h3 << 4)),
              64'(owners_split(1, 2) & ~(16'h3 << 4)));
        check("R7 valid_nxt", 64'(valid_nxt), 8'b1111_0111);
        e = ranks_up();
        e[0 +: AW] = 1; e[AW +: AW] = 2; e[2*AW +: AW] = 0;
        check("R6 ranks after fill", 64'(age_nxt), 64'(e));
        @(negedge clk);
        check("R8 no strobe without request", 64'(out_valid), 0);
    endtask

    task automatic t_below_quota();
        line_valid = '1; line_owner = owners_split(1, 2); line_age = ranks_up();
        access(0, 0, 1, 5);
        check("R2 victim other core", 64'(out_way), 7);
        check("R2 src", 64'(out_src), 2);
        check("R5 owner", 64'(owner_nxt[7*CW +: CW]), 1);
    endtask

    task automatic t_at_quota();
        line_valid = '1; line_owner = owners_split(1, 2); line_age = ranks_up();
        access(0, 0, 1, 4);
        check("R3 victim own line", 64'(out_way), 3);
        check("R3 src", 64'(out_src), 3);
        check("R6 ranks", 64'(age_nxt[0 +: 4*AW]), 64'({3'd0, 3'd3, 3'd2, 3'd1}));
    endtask

    task automatic t_fallback();
        line_valid = '1; line_owner = owners_split(1, 1); line_age = ranks_up();
        access(0, 0, 1, 9);
        check("R4 under quota, no other owner", 64'(out_way), 7);
        check("R4 src own", 64'(out_src), 3);
        line_age = ranks_down();
        access(0, 0, 3, 0);
        check("R4 over quota, nothing owned", 64'(out_way), 0);
        check("R4 src other", 64'(out_src), 2);
    endtask

    task automatic t_hit();
        logic [WAYS*AW-1:0] e;
        line_valid = 8'b0111_1111; line_owner = owners_split(0, 3);
        line_age = ranks_up();
        access(1, 5, 2, 0);
        check("R5 hit src", 64'(out_src), 0);
        check("R5 hit keeps owners", 64'(owner_nxt), 64'(owners_split(0, 3)));
        check("R1 hit ignores invalid way", 64'(out_way), 5);
        e = ranks_up();
        for (int i = 0; i < 5; i++) e[i*AW +: AW] = AW'(i + 1);
        e[5*AW +: AW] = 0;
        check("R6 ranks after hit", 64'(age_nxt), 64'(e));
        check("R7 valid after hit", 64'(valid_nxt), 8'b0111_1111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_invalid_first();
        t_below_quota();
        t_at_quota();
        t_fallback();
        t_hit();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule